// File: doc/BRIEF.md
# Instruction-Hash Control-Flow Monitor

This block sits beside a processor core and checks, one retired instruction at a time, that the core's execution follows a precomputed graph of permitted behaviour. Each retired instruction arrives as a beat carrying its 32-bit address and 32-bit instruction word. The block folds the beat down to a 4-bit hash. It then tests that hash against the set of hashes the current graph state allows, and steps to the successor state that the hash selects. A hash the current state does not allow is a control-flow violation. The block answers it with a one-cycle `recover` pulse toward the core and restarts the graph at its start entry.

The graph lives in a local memory. Each entry packs a 16-bit allowed-hash vector (bit `h` set means hash value `h` is allowed) above a successor base pointer of `GADDR_W` bits (default 10; the pointer format allows up to 14). A state with several successors keeps them in consecutive entries starting at the base pointer. The successor is chosen by the rank of the matching bit, which is the number of allowed bits below it, so a branch costs no extra compare stage. Software preloads the memory through a plain write port while `mon_en` is low.

Instruction beats use valid/ready. A beat transfers on a rising clock edge where `ins_valid` and `ins_ready` are both high. `ins_ready` depends only on `mon_en` and never on `ins_valid`. It is low whenever `mon_en` is low, and also in the first enabled cycle, while the start entry is fetched. After that it stays high, so every enabled cycle can take a beat. A source facing low ready must hold its beat; beats offered while ready is low are not checked.

Top module: `insn_flow_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `recover` and `ins_ready` are 0.
- R2: `ins_ready` is 0 in the first cycle `mon_en` is high and 1 in every later cycle while `mon_en` stays high.
- R3: The hash of a beat is the XOR of the eight 4-bit nibbles of (`ins_addr` XOR `ins_word`).
- R4: An accepted beat whose hash bit is clear in the current entry's vector (entry bits [GADDR_W+15:GADDR_W]) raises `recover` for exactly the following cycle.
- R5: An accepted beat whose hash bit is set moves the state to base pointer (entry bits [GADDR_W-1:0]) plus the count of set vector bits below the hash position, modulo the memory depth.
- R6: After a violation, the next accepted beat is checked against the entry at `START_ADDR` (default 0).
- R7: A cycle without an accepted beat changes no state and raises no `recover`.
- R8: While `mon_en` is low, a `cfg_we` cycle stores `cfg_data` at `cfg_addr`. While `mon_en` is high, writes are ignored.
- R9: Lowering and raising `mon_en` restarts checking at `START_ADDR`, and no `recover` follows a cycle in which the monitor was disabled.
- R10: `ins_ready` is 0 whenever `mon_en` is 0, whatever `ins_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Enables checking; low allows graph preload |
| ins_valid | input | 1 | Instruction beat valid |
| ins_ready | output | 1 | Monitor accepts a beat this cycle |
| ins_addr | input | WORD_W | Address of the retired instruction |
| ins_word | input | WORD_W | Retired instruction word |
| cfg_we | input | 1 | Graph memory write enable |
| cfg_addr | input | GADDR_W | Graph memory write address |
| cfg_data | input | 16+GADDR_W | Entry: vector in upper 16 bits, base pointer below |
| recover | output | 1 | One-cycle reset/recover pulse to the core |

## Verification
The checker follows the handshake on every cycle. It checks that ready is off while the monitor is disabled and during the fetch cycle, that it is on once enabled, and that each recover pulse follows an accepted beat. The hash fold, the rank-based successor choice, the restart at the start entry and the write gating all depend on memory contents. Only the bench's reference model can show them, because it holds its own copy of the graph and predicts `recover` for every beat, including back-to-back violations and writes made while enabled.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam int HASH_W = 4;
  localparam int VEC_W  = 1 << HASH_W;
  typedef logic [HASH_W-1:0] hash_t;
  typedef logic [VEC_W-1:0]  hvec_t;
endpackage

// File: rtl/ifg_hash.sv
module ifg_hash
  import ifg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] word,
  output hash_t             hash
);
  localparam int NIB = WORD_W / HASH_W;

  logic [WORD_W-1:0] mix;
  assign mix = addr ^ word;

  // fold every nibble of the mixed word into one
  always_comb begin
    hash = '0;
    for (int i = 0; i < NIB; i++) begin
      hash = hash ^ mix[i*HASH_W +: HASH_W];
    end
  end
endmodule

// File: rtl/ifg_match.sv
module ifg_match
  import ifg_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  hash_t             hash,
  input  hvec_t             allowed,
  input  logic [PTR_W-1:0]  base,
  output logic              hit,
  output logic [PTR_W-1:0]  next_ptr
);
  hvec_t            sel;
  hvec_t            below;
  logic [HASH_W:0]  rank;

  assign sel   = hvec_t'(1) << hash;
  assign hit   = |(sel & allowed);
  assign below = allowed & (sel - hvec_t'(1));

  // rank of the matching bit among the allowed ones
  always_comb begin
    rank = '0;
    for (int i = 0; i < VEC_W; i++) begin
      rank = rank + (HASH_W+1)'(below[i]);
    end
  end

  assign next_ptr = base + PTR_W'(rank);
endmodule

// File: rtl/ifg_graph_mem.sv
module ifg_graph_mem #(
  parameter int AW = 10,
  parameter int DW = 26
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/insn_flow_guard.sv
module insn_flow_guard
  import ifg_pkg::*;
#(
  parameter int                 WORD_W     = 32,
  parameter int                 GADDR_W    = 10,
  parameter logic [GADDR_W-1:0] START_ADDR = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mon_en,
  input  logic                       ins_valid,
  output logic                       ins_ready,
  input  logic [WORD_W-1:0]          ins_addr,
  input  logic [WORD_W-1:0]          ins_word,
  input  logic                       cfg_we,
  input  logic [GADDR_W-1:0]         cfg_addr,
  input  logic [VEC_W+GADDR_W-1:0]   cfg_data,
  output logic                       recover
);
  localparam int ENTRY_W = VEC_W + GADDR_W;

  logic               loaded;
  logic               accept;
  logic               hit;
  hash_t              hash;
  hvec_t              cur_vec;
  logic [GADDR_W-1:0] cur_base;
  logic [GADDR_W-1:0] next_ptr;
  logic [ENTRY_W-1:0] cur_entry;
  logic               rd_en;
  logic [GADDR_W-1:0] rd_addr;

  assign ins_ready = mon_en & loaded;
  assign accept    = ins_valid & ins_ready;
  assign cur_vec   = cur_entry[ENTRY_W-1:GADDR_W];
  assign cur_base  = cur_entry[GADDR_W-1:0];

  ifg_hash #(.WORD_W(WORD_W)) u_hash (
    .addr (ins_addr),
    .word (ins_word),
    .hash (hash)
  );

  ifg_match #(.PTR_W(GADDR_W)) u_match (
    .hash     (hash),
    .allowed  (cur_vec),
    .base     (cur_base),
    .hit      (hit),
    .next_ptr (next_ptr)
  );

  // one read per beat: successor on a hit, start entry otherwise
  assign rd_en   = (mon_en & ~loaded) | accept;
  assign rd_addr = (accept & hit) ? next_ptr : START_ADDR;

  ifg_graph_mem #(.AW(GADDR_W), .DW(ENTRY_W)) u_mem (
    .clk   (clk),
    .we    (cfg_we & ~mon_en),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (cur_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded  <= 1'b0;
      recover <= 1'b0;
    end else begin
      loaded  <= mon_en;
      recover <= accept & ~hit;
    end
  end
endmodule

// File: rtl/ifg_checker.sv
module ifg_checker (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic ins_valid,
  input logic ins_ready,
  input logic recover
);
  p_not_ready_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> !ins_ready);

  p_fetch_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !$past(mon_en)) |-> !ins_ready);

  p_ready_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mon_en) && mon_en) |-> ins_ready);

  p_recover_follows_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> $past(ins_valid && ins_ready));

  p_no_recover_after_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> $past(mon_en));
endmodule

bind insn_flow_guard ifg_checker u_ifg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mon_en    (mon_en),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .recover   (recover)
);

// File: tb/insn_flow_guard_test.sv
`timescale 1ns/1ps
module insn_flow_guard_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int EW    = 16 + AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_en = 1'b0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [31:0]   ins_addr = '0;
  logic [31:0]   ins_word = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [EW-1:0] cfg_data = '0;
  logic          recover;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    done = 0;

  // reference model state
  logic [EW-1:0] model [DEPTH];
  int            m_cur = 0;
  bit            m_loaded = 0;
  bit            exp_rec = 0;

  always #2.5 clk = ~clk;

  insn_flow_guard uut (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_word(ins_word),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .recover(recover)
  );

  function automatic int fold(input logic [31:0] a, input logic [31:0] w);
    logic [31:0] m;
    int h;
    m = a ^ w;
    h = 0;
    for (int i = 0; i < 8; i++) h = h ^ int'(m[i*4 +: 4]);
    return h;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_loaded = 0;
      exp_rec  = 0;
    end else begin
      bit acc;
      acc = ins_valid && mon_en && m_loaded;
      exp_rec = 0;
      if (acc) begin
        int h;
        int cnt;
        logic [15:0] v;
        h = fold(ins_addr, ins_word);
        v = model[m_cur][EW-1:AW];
        if (v[h]) begin
          cnt = 0;
          for (int i = 0; i < h; i++) if (v[i]) cnt++;
          m_cur = (int'(model[m_cur][AW-1:0]) + cnt) % DEPTH;
        end else begin
          m_cur   = 0;
          exp_rec = 1;
        end
      end
      if (mon_en && !m_loaded) m_cur = 0;
      if (!mon_en && cfg_we) model[cfg_addr] = cfg_data;
      m_loaded = mon_en;
    end
    #1;
    total++;
    if (recover !== exp_rec) begin
      bad++;
      $display("FAIL %s recover act=%0b exp=%0b", tag, recover, exp_rec);
    end
    total++;
    if (ins_ready !== (mon_en && m_loaded)) begin
      bad++;
      $display("FAIL %s ins_ready act=%0b exp=%0b", tag, ins_ready, (mon_en && m_loaded));
    end
  end

  task automatic wr(input int a, input logic [15:0] v, input int p);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = AW'(a);
    cfg_data = {v, AW'(p)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic beat(input logic [31:0] a, input logic [3:0] h);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_addr  = a;
    ins_word  = a ^ {28'h0, h};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ins_valid = 1'b0;
      ins_addr  = $urandom;
      ins_word  = $urandom;
    end
  endtask

  task automatic set_en(input bit e);
    @(negedge clk);
    ins_valid = 1'b0;
    mon_en    = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    total++;
    if (recover !== 1'b0 || ins_ready !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs act=%0b%0b exp=00", recover, ins_ready);
    end
    rst_n = 1'b1;
    idle(2);

    // R8: preload while disabled
    tag = "R8";
    for (int a = 0; a < DEPTH; a++) wr(a, 16'h0000, 0);
    wr(0,  16'h0884, 10);   // hashes 2,7,11 -> entries 10,11,12
    wr(10, 16'h0020, 0);    // hash 5 -> 0
    wr(11, 16'h0200, 0);    // hash 9 -> 0
    wr(12, 16'h8000, 20);   // hash 15 -> 20
    wr(20, 16'hFFFF, 30);   // any hash -> 30+h
    wr(31, 16'h0001, 0);    // hash 0 -> 0

    // R2 and R10: enable with valid held high
    tag = "R2";
    @(negedge clk);
    mon_en = 1'b1;
    ins_valid = 1'b1;
    ins_addr = 32'h100;
    ins_word = 32'h100 ^ 32'h2;
    @(negedge clk);   // ready still low in the fetch cycle
    tag = "R5";
    beat(32'h104, 4'd5);    // from 10
    beat(32'h108, 4'd7);    // 0 -> 11
    beat(32'h10c, 4'd9);    // 11 -> 0
    beat(32'h110, 4'd11);   // 0 -> 12
    beat(32'h114, 4'd15);   // 12 -> 20
    beat(32'h118, 4'd1);    // 20 -> 31
    beat(32'h11c, 4'd0);    // 31 -> 0

    // R4 and R6: violation then restart
    tag = "R4";
    beat(32'h200, 4'd3);
    tag = "R6";
    beat(32'h204, 4'd2);
    beat(32'h208, 4'd5);
    tag = "R4";
    beat(32'h20c, 4'd4);    // violation at start
    beat(32'h210, 4'd6);    // back-to-back violation
    tag = "R6";
    beat(32'h214, 4'd7);

    // R7: gaps carry no beat
    tag = "R7";
    idle(5);
    beat(32'h218, 4'd9);

    // R8: writes while enabled are ignored
    tag = "R8";
    @(negedge clk);
    ins_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = '0;
    cfg_data = {16'h0008, AW'(40)};
    @(negedge clk);
    cfg_we = 1'b0;
    beat(32'h300, 4'd2);
    beat(32'h304, 4'd3);

    // R9 and R10: disable mid-graph, then re-enable
    tag = "R9";
    beat(32'h308, 4'd11);   // 0 -> 12
    set_en(1'b0);
    tag = "R10";
    @(negedge clk);
    ins_valid = 1'b1;
    ins_addr = 32'h400;
    ins_word = 32'h0;
    idle(2);
    tag = "R9";
    set_en(1'b1);
    idle(1);
    beat(32'h40c, 4'd2);    // restarted at 0
    beat(32'h410, 4'd5);

    // R3: arbitrary words through the fold
    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ins_valid = ($urandom % 4) != 0;
      ins_addr  = $urandom;
      ins_word  = $urandom;
    end
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule